// File: doc/BRIEF.md
# Load-Step Gain Scheduler Sequencer

This block sits beside the repetitive voltage controller of one inverter phase and steers it through a load change. It has two inputs: a pulse from an external load monitor that reports a step in the load, and a pulse marking each boundary of the fundamental period. At the default setting a period is 240 samples at 12 kHz.

When a step has been reported, the block waits for the next period boundary and then does three things:
- It raises a replay flag for exactly one period. During that period the controller plays back the previous period's actuation signal and does not close the loop.
- It issues a one-cycle strobe so that freshly computed compensator coefficients are loaded during that open-loop period.
- It sets the internal-model factor Q to a low value and then raises it in equal steps at each following boundary. After a fixed number of periods Q is back at its nominal value.

The learning gain is not touched by this block.

Q is presented as an unsigned fixed-point number whose scaling is a parameter. The defaults are a nominal value of 16220 and a low value of 9830, which are 0.99 and 0.6 with 14 fraction bits, and a ramp of three periods.

Top module: `gain_sched_seq`

## Requirements
- R1: After reset the block is idle: `q_value_o` equals Q_NOM (16220 by default), and `replay_en_o` and `coef_upd_o` are 0.
- R2: A load-step pulse that arrives with no period boundary in the same cycle changes no output. It is held until the next boundary.
- R3: On the clock edge that samples a boundary while a step is pending, the block does three things. `replay_en_o` goes to 1 and `q_value_o` goes to Q_LOW (9830 by default). `coef_upd_o` goes to 1 for exactly one cycle.
- R4: The replay flag stays 1 for exactly one period and clears at the next boundary if no new step is pending.
- R5: Ramp period k, for k = 1..RAMP_PERIODS, holds `q_value_o` at Q_LOW + (k-1)*STEP, where STEP = (Q_NOM-Q_LOW)/RAMP_PERIODS. With the defaults the values are 9830, 11960 and 14090.
- R6: At the boundary that ends the last ramp period, `q_value_o` returns to Q_NOM and the block is idle again.
- R7: A step that is pending at a boundary during replay or the ramp restarts the sequence at replay, with a fresh coefficient strobe.
- R8: A step pulse in the same cycle as a boundary is acted on at that boundary.
- R9: Several step pulses within one period cause a single restart and a single coefficient strobe.
- R10: `q_value_o` and `replay_en_o` change only on the edge after a cycle in which `period_tick_i` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_step_i | input | 1 | Load-step detected pulse |
| period_tick_i | input | 1 | Fundamental period boundary pulse |
| q_value_o | output | QW | Internal-model factor Q, unsigned fixed point |
| replay_en_o | output | 1 | Open-loop replay of last recorded period |
| coef_upd_o | output | 1 | One-cycle compensator coefficient load strobe |

## Verification
The bench aims at the following corner cases:

- **Step inside a period.** A step arrives mid-period and sits idle for many cycles. A design that reacted at once would switch the loop mode partway through a period.
- **Step on a boundary.** A step coincides with a boundary. A design that only looked at the held flag would lose a whole period.
- **Restart during replay or the ramp.** A step lands during replay or partway through the ramp. A design with a wrong restart would either carry on ramping from a stale Q or skip the coefficient strobe.
- **Bursts of pulses.** Several pulses arrive in one period. This exposes designs that emit duplicate strobes.

Every cycle is compared against a behavioural model, so an off-by-one in the ramp length or step value shows up as a wrong Q in a specific period.

// File: rtl/gss_pkg.sv
package gss_pkg;
   typedef enum logic [1:0] {
      GS_IDLE   = 2'd0,
      GS_REPLAY = 2'd1,
      GS_RAMP   = 2'd2
   } gs_state_e;
endpackage

// File: rtl/gss_pending.sv
// Holds a load-step report until the next period boundary.
module gss_pending (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic tick_i,
   output logic act_o
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (tick_i)
         pend_q <= 1'b0;
      else if (step_i)
         pend_q <= 1'b1;
   end

   // a pulse in the boundary cycle counts as pending at that boundary
   assign act_o = pend_q | step_i;
endmodule

// File: rtl/gss_fsm.sv
// Sequences replay and ramp periods, advancing only at period boundaries.
module gss_fsm
   import gss_pkg::*;
#(
   parameter int RAMP_PERIODS = 3,
   parameter int IW           = $clog2(RAMP_PERIODS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          act_i,
   output gs_state_e     state_o,
   output logic [IW-1:0] idx_o,
   output logic          coef_o
);
   localparam logic [IW-1:0] LAST_IDX = IW'(RAMP_PERIODS);
   localparam logic [IW-1:0] ONE_IDX  = IW'(1);

   gs_state_e     st_q, st_d;
   logic [IW-1:0] idx_q, idx_d;
   logic          enter;

   assign enter = tick_i & act_i;

   always_comb begin
      st_d  = st_q;
      idx_d = idx_q;
      if (enter) begin
         st_d  = GS_REPLAY;
         idx_d = '0;
      end else if (tick_i) begin
         unique case (st_q)
            GS_REPLAY: begin
               st_d  = GS_RAMP;
               idx_d = ONE_IDX;
            end
            GS_RAMP: begin
               if (idx_q >= LAST_IDX) begin
                  st_d  = GS_IDLE;
                  idx_d = '0;
               end else begin
                  idx_d = idx_q + ONE_IDX;
               end
            end
            default: begin
               st_d  = GS_IDLE;
               idx_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= GS_IDLE;
         idx_q  <= '0;
         coef_o <= 1'b0;
      end else begin
         st_q   <= st_d;
         idx_q  <= idx_d;
         coef_o <= enter;
      end
   end

   assign state_o = st_q;
   assign idx_o   = idx_q;
endmodule

// File: rtl/gss_qgen.sv
// Maps sequencer state to the Q value presented to the controller.
module gss_qgen
   import gss_pkg::*;
#(
   parameter int QW           = 16,
   parameter int Q_NOM        = 16220,
   parameter int Q_LOW        = 9830,
   parameter int RAMP_PERIODS = 3,
   parameter int IW           = $clog2(RAMP_PERIODS + 1)
) (
   input  gs_state_e     state_i,
   input  logic [IW-1:0] idx_i,
   output logic [QW-1:0] q_o
);
   localparam int            STEP   = (Q_NOM - Q_LOW) / RAMP_PERIODS;
   localparam logic [QW-1:0] NOM_V  = QW'(Q_NOM);
   localparam logic [QW-1:0] LOW_V  = QW'(Q_LOW);
   localparam logic [QW-1:0] STEP_V = QW'(STEP);

   logic [QW-1:0] ramp_v;

   generate
      if (RAMP_PERIODS == 1) begin : g_single
         assign ramp_v = LOW_V;
      end else begin : g_linear
         logic [QW-1:0] k_m1;
         assign k_m1   = QW'(idx_i) - QW'(1);
         assign ramp_v = LOW_V + k_m1 * STEP_V;
      end
   endgenerate

   always_comb begin
      unique case (state_i)
         GS_REPLAY: q_o = LOW_V;
         GS_RAMP:   q_o = ramp_v;
         default:   q_o = NOM_V;
      endcase
   end
endmodule

// File: rtl/gain_sched_seq.sv
module gain_sched_seq
   import gss_pkg::*;
#(
   parameter int QW           = 16,
   parameter int Q_NOM        = 16220,
   parameter int Q_LOW        = 9830,
   parameter int RAMP_PERIODS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_step_i,
   input  logic          period_tick_i,
   output logic [QW-1:0] q_value_o,
   output logic          replay_en_o,
   output logic          coef_upd_o
);
   localparam int IW = $clog2(RAMP_PERIODS + 1);

   generate
      if (RAMP_PERIODS < 1) begin : g_bad_ramp
         $error("RAMP_PERIODS must be at least 1");
      end
      if (Q_LOW >= Q_NOM) begin : g_bad_order
         $error("Q_LOW must be below Q_NOM");
      end
      if (Q_NOM >= (1 << QW)) begin : g_bad_width
         $error("Q_NOM does not fit in QW bits");
      end
   endgenerate

   logic          act;
   gs_state_e     st;
   logic [IW-1:0] idx;

   gss_pending pend_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (load_step_i),
      .tick_i (period_tick_i),
      .act_o  (act)
   );

   gss_fsm #(.RAMP_PERIODS(RAMP_PERIODS), .IW(IW)) fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (period_tick_i),
      .act_i   (act),
      .state_o (st),
      .idx_o   (idx),
      .coef_o  (coef_upd_o)
   );

   gss_qgen #(
      .QW(QW), .Q_NOM(Q_NOM), .Q_LOW(Q_LOW),
      .RAMP_PERIODS(RAMP_PERIODS), .IW(IW)
   ) qgen_i (
      .state_i (st),
      .idx_i   (idx),
      .q_o     (q_value_o)
   );

   assign replay_en_o = (st == GS_REPLAY);
endmodule

// File: rtl/gss_chk.sv
module gss_chk #(
   parameter int QW    = 16,
   parameter int Q_NOM = 16220,
   parameter int Q_LOW = 9830
) (
   input logic          clk,
   input logic          rst_n,
   input logic          load_step_i,
   input logic          period_tick_i,
   input logic [QW-1:0] q_value_o,
   input logic          replay_en_o,
   input logic          coef_upd_o
);
   // R3
   coef_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_upd_o |=> !coef_upd_o);
   // R3
   coef_with_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_upd_o |-> (replay_en_o && q_value_o == QW'(Q_LOW)));
   // R3
   replay_start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(replay_en_o) |-> coef_upd_o);
   // R10
   q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(period_tick_i) |-> $stable(q_value_o));
   // R10
   replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(period_tick_i) |-> $stable(replay_en_o));
   // R5
   q_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_value_o >= QW'(Q_LOW)) && (q_value_o <= QW'(Q_NOM)));
   // R2
   coef_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_upd_o |-> $past(period_tick_i));
endmodule

bind gain_sched_seq gss_chk #(.QW(QW), .Q_NOM(Q_NOM), .Q_LOW(Q_LOW)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .load_step_i   (load_step_i),
   .period_tick_i (period_tick_i),
   .q_value_o     (q_value_o),
   .replay_en_o   (replay_en_o),
   .coef_upd_o    (coef_upd_o)
);

// File: tb/gain_sched_seq_tb_top.sv
`timescale 1ns/1ps
module gain_sched_seq_tb_top;
   localparam int QW = 16, QN = 16220, QL = 9830, NR = 3;
   localparam int STEP = (QN - QL) / NR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step = 1'b0;
   logic tick = 1'b0;
   logic [QW-1:0] q;
   logic replay, coef;

   int checks = 0, fails = 0, coef_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gain_sched_seq #(.QW(QW), .Q_NOM(QN), .Q_LOW(QL), .RAMP_PERIODS(NR)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_step_i(step), .period_tick_i(tick),
      .q_value_o(q), .replay_en_o(replay), .coef_upd_o(coef)
   );

   // behavioural reference: 0 idle, 1 replay, 2 ramp
   int m_mode = 0, m_k = 0, m_pulses = 0;
   bit m_pend = 0, m_coef = 0;
   string m_tag = "R1";

   always @(posedge clk) begin
      m_coef = 0;
      if (!rst_n) begin
         m_mode = 0; m_k = 0; m_pend = 0; m_pulses = 0; m_tag = "R1";
      end else if (tick) begin
         if (m_pend || step) begin
            if (m_pulses + (step ? 1 : 0) > 1) m_tag = "R9";
            else if (step && !m_pend) m_tag = "R8";
            else if (m_mode != 0) m_tag = "R7";
            else m_tag = "R3";
            m_mode = 1; m_k = 0; m_coef = 1;
         end else if (m_mode == 1) begin
            m_mode = 2; m_k = 1; m_tag = "R4";
         end else if (m_mode == 2) begin
            if (m_k == NR) begin m_mode = 0; m_k = 0; m_tag = "R6"; end
            else begin m_k = m_k + 1; m_tag = "R5"; end
         end else m_tag = "R10";
         m_pend = 0; m_pulses = 0;
      end else if (step) begin
         m_pend = 1; m_pulses = m_pulses + 1; m_tag = "R2";
      end
   end

   function automatic int exp_q();
      if (m_mode == 1) return QL;
      if (m_mode == 2) return QL + (m_k - 1) * STEP;
      return QN;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk(m_tag, int'(q), exp_q());
         chk(m_tag, int'(replay), (m_mode == 1) ? 1 : 0);
         chk(m_tag, int'(coef), int'(m_coef));
         if (coef) coef_cnt++;
      end
   end

   task automatic cyc(bit s, bit t);
      @(negedge clk);
      step = s; tick = t;
   endtask

   // one period of len cycles; step pulses at cycle indices in mask (bit i)
   task automatic period(int len, int mask);
      for (int i = 0; i < len; i++)
         cyc((i < 32) ? mask[i] : 1'b0, (i == len - 1));
   endtask

   initial begin
      repeat (4) cyc(0, 0);
      @(negedge clk);
      chk("R1", int'(q), QN);
      chk("R1", int'(replay), 0);
      chk("R1", int'(coef), 0);
      rst_n = 1'b1;
      period(10, 0);
      // R2: mid-period step, long wait
      period(240, 32'h0000_0100);
      // full replay + ramp to idle (R4, R5, R6)
      repeat (5) period(12, 0);
      chk("R6", int'(q), QN);
      // R8: step on the boundary cycle
      period(9, 32'h0000_0100);
      repeat (2) period(9, 0);
      // R7: restart during ramp 2
      period(8, 32'h0000_0008);
      period(8, 0);
      // R7: restart during replay
      period(8, 32'h0000_0004);
      // R9: burst of pulses in one period
      coef_cnt = 0;
      period(16, 32'h0000_0A52);
      cyc(0, 0);
      chk("R9", coef_cnt, 1);
      repeat (6) period(240, 0);
      chk("R6", int'(q), QN);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule